// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Integer Pipeline

This block picks the operands seen by the execute stage of an in-order integer pipeline with five stages. The instruction in execute names up to two source registers. For each source, the block compares the register number with the destination of the instruction one slot ahead, which is held in the execute/memory pipeline register. It also compares it with the destination of the instruction two slots ahead, which is held in the memory/writeback pipeline register. A match replaces the stale register-file value with the newer result. The check against the memory/writeback register covers a producer that retires in the cycle the consumer reads.

The forwarded first source feeds the ALU A input. That input can instead take the next-PC value for branch-target arithmetic. The forwarded second source feeds the ALU B input, which can instead take the sign-extended immediate. The forwarded second source also drives the store write-data port on its own path, so a store can write a value that was just produced. The register file writes in the first half of a cycle and reads in the second half. An instruction three slots behind its producer therefore reads the correct value directly, and no bypass is needed for it. The block is purely combinational. Load-use stalls are handled elsewhere.

Top module: `opnd_bypass`

## Requirements
- R1: When neither pipeline register matches a source, that source takes its register-file value.
- R2: When the execute/memory register has its write enable set, is not a load, and its destination equals a source, that source takes the execute/memory ALU result. Each source is checked independently.
- R3: When only the memory/writeback register (write enable set) matches a source, that source takes the writeback value.
- R4: When both registers match the same source, the execute/memory value is used, because it belongs to the younger producer.
- R5: A producer whose write enable is clear is never forwarded.
- R6: With ZERO_REG_FIXED=1, a source equal to register number 0 is never forwarded, even when a producer names destination 0.
- R7: A load in the execute/memory register is never forwarded from there. The source then falls back to the memory/writeback match, and otherwise to the register file.
- R8: With opa_use_npc=1, ALU A takes the next-PC value. With opb_use_imm=1, ALU B takes the immediate. Otherwise each takes its forwarded source.
- R9: Store write-data always equals the forwarded second source, whatever opb_use_imm is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | REG_ADDR_W | First source register number in execute |
| ex_src2 | input | REG_ADDR_W | Second source register number in execute |
| ex_src1_rf | input | DATA_W | Register-file value read for source 1 |
| ex_src2_rf | input | DATA_W | Register-file value read for source 2 |
| ex_imm | input | DATA_W | Sign-extended immediate |
| ex_npc | input | DATA_W | Next-PC value of the execute instruction |
| opa_use_npc | input | 1 | ALU A takes next-PC instead of source 1 |
| opb_use_imm | input | 1 | ALU B takes immediate instead of source 2 |
| em_wr_en | input | 1 | Execute/memory instruction writes a register |
| em_is_load | input | 1 | Execute/memory instruction is a load |
| em_dst | input | REG_ADDR_W | Execute/memory destination register |
| em_result | input | DATA_W | Execute/memory ALU result |
| mw_wr_en | input | 1 | Memory/writeback instruction writes a register |
| mw_dst | input | REG_ADDR_W | Memory/writeback destination register |
| mw_result | input | DATA_W | Memory/writeback result (ALU or loaded data) |
| alu_a | output | DATA_W | ALU A operand |
| alu_b | output | DATA_W | ALU B operand |
| store_wdata | output | DATA_W | Data-memory write data |

## Verification
Some properties are checked by assertions whenever the inputs change. A load in the execute/memory register never becomes a bypass source. A producer without write enable is never forwarded. Store data tracks ALU B whenever the immediate is not selected, and ALU A equals next-PC whenever that choice is made. Only the bench scenarios can show that the right value reaches each operand. These scenarios cover the priority of the younger producer when both registers match, the exemption of register 0, and the fallback of a load hit to an older match.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_EM  = 2'd1,
      SRC_MW  = 2'd2
   } byp_src_e;
endpackage

// File: rtl/byp_src_pick.sv
module byp_src_pick
   import opnd_bypass_pkg::*;
#(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src_num,
   input  logic                  em_wr_en,
   input  logic                  em_is_load,
   input  logic [REG_ADDR_W-1:0] em_dst,
   input  logic                  mw_wr_en,
   input  logic [REG_ADDR_W-1:0] mw_dst,
   output byp_src_e              pick
);
   logic src_live;
   logic em_hit;
   logic mw_hit;

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         assign src_live = (src_num != '0);
      end else begin : g_zero_plain
         assign src_live = 1'b1;
      end
   endgenerate

   assign em_hit = src_live && em_wr_en && !em_is_load && (em_dst == src_num);
   assign mw_hit = src_live && mw_wr_en && (mw_dst == src_num);

   always_comb begin
      if (em_hit)      pick = SRC_EM;
      else if (mw_hit) pick = SRC_MW;
      else             pick = SRC_RF;
   end

   always_comb begin
      // R7: a load's data is never taken from the execute/memory slot
      a_r7_no_load_from_em: assert (!(em_is_load && pick == SRC_EM));
      // R5: no enabled producer means no bypass
      a_r5_no_enable_no_bypass: assert (em_wr_en || mw_wr_en || pick == SRC_RF);
   end
endmodule

// File: rtl/byp_data_mux.sv
module byp_data_mux
   import opnd_bypass_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  byp_src_e          pick,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] em_val,
   input  logic [DATA_W-1:0] mw_val,
   output logic [DATA_W-1:0] out_val
);
   always_comb begin
      unique case (pick)
         SRC_EM:  out_val = em_val;
         SRC_MW:  out_val = mw_val;
         default: out_val = rf_val;
      endcase
   end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
   import opnd_bypass_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] ex_src1,
   input  logic [REG_ADDR_W-1:0] ex_src2,
   input  logic [DATA_W-1:0]     ex_src1_rf,
   input  logic [DATA_W-1:0]     ex_src2_rf,
   input  logic [DATA_W-1:0]     ex_imm,
   input  logic [DATA_W-1:0]     ex_npc,
   input  logic                  opa_use_npc,
   input  logic                  opb_use_imm,
   input  logic                  em_wr_en,
   input  logic                  em_is_load,
   input  logic [REG_ADDR_W-1:0] em_dst,
   input  logic [DATA_W-1:0]     em_result,
   input  logic                  mw_wr_en,
   input  logic [REG_ADDR_W-1:0] mw_dst,
   input  logic [DATA_W-1:0]     mw_result,
   output logic [DATA_W-1:0]     alu_a,
   output logic [DATA_W-1:0]     alu_b,
   output logic [DATA_W-1:0]     store_wdata
);
   localparam int NUM_SRC = 2;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("opnd_bypass: DATA_W must be at least 1");
      end
      if (REG_ADDR_W < 1) begin : g_bad_addr_w
         $error("opnd_bypass: REG_ADDR_W must be at least 1");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] src_num [NUM_SRC];
   logic [DATA_W-1:0]     src_rf  [NUM_SRC];
   logic [DATA_W-1:0]     src_fwd [NUM_SRC];
   byp_src_e              src_pick[NUM_SRC];

   assign src_num[0] = ex_src1;
   assign src_num[1] = ex_src2;
   assign src_rf[0]  = ex_src1_rf;
   assign src_rf[1]  = ex_src2_rf;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         byp_src_pick #(
            .REG_ADDR_W    (REG_ADDR_W),
            .ZERO_REG_FIXED(ZERO_REG_FIXED)
         ) pick_i (
            .src_num   (src_num[g]),
            .em_wr_en  (em_wr_en),
            .em_is_load(em_is_load),
            .em_dst    (em_dst),
            .mw_wr_en  (mw_wr_en),
            .mw_dst    (mw_dst),
            .pick      (src_pick[g])
         );
         byp_data_mux #(
            .DATA_W(DATA_W)
         ) mux_i (
            .pick   (src_pick[g]),
            .rf_val (src_rf[g]),
            .em_val (em_result),
            .mw_val (mw_result),
            .out_val(src_fwd[g])
         );
      end
   endgenerate

   assign alu_a       = opa_use_npc ? ex_npc : src_fwd[0];
   assign alu_b       = opb_use_imm ? ex_imm : src_fwd[1];
   assign store_wdata = src_fwd[1];

   always_comb begin
      // R9: store data follows the second forwarded source, same as ALU B when not immediate
      a_r9_store_tracks_b: assert (opb_use_imm || store_wdata == alu_b);
      // R8: next-PC choice reaches ALU A
      a_r8_npc_on_a: assert (!opa_use_npc || alu_a == ex_npc);
      // R4: a non-load execute/memory hit on source 1 wins over everything else
      a_r4_em_priority: assert (opa_use_npc || em_is_load || !em_wr_en ||
                                em_dst != ex_src1 ||
                                (ZERO_REG_FIXED && ex_src1 == '0) ||
                                alu_a == em_result);
   end
endmodule

// File: tb/opnd_bypass_tb_top.sv
module opnd_bypass_tb_top;
   localparam int DW = 32;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0] ex_src1, ex_src2, em_dst, mw_dst;
   logic [DW-1:0] ex_src1_rf, ex_src2_rf, ex_imm, ex_npc, em_result, mw_result;
   logic          opa_use_npc, opb_use_imm, em_wr_en, em_is_load, mw_wr_en;
   logic [DW-1:0] alu_a, alu_b, store_wdata;

   int checks = 0;
   int errors = 0;

   localparam logic [DW-1:0] RF1 = 32'h1111_1111;
   localparam logic [DW-1:0] RF2 = 32'h2222_2222;
   localparam logic [DW-1:0] EMV = 32'hAAAA_0001;
   localparam logic [DW-1:0] MWV = 32'hBBBB_0002;
   localparam logic [DW-1:0] IMM = 32'h0000_0040;
   localparam logic [DW-1:0] NPC = 32'h0000_0100;

   opnd_bypass #(.DATA_W(DW), .REG_ADDR_W(AW), .ZERO_REG_FIXED(1'b1)) dut_i (
      .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_src1_rf(ex_src1_rf), .ex_src2_rf(ex_src2_rf),
      .ex_imm(ex_imm), .ex_npc(ex_npc), .opa_use_npc(opa_use_npc), .opb_use_imm(opb_use_imm),
      .em_wr_en(em_wr_en), .em_is_load(em_is_load), .em_dst(em_dst), .em_result(em_result),
      .mw_wr_en(mw_wr_en), .mw_dst(mw_dst), .mw_result(mw_result),
      .alu_a(alu_a), .alu_b(alu_b), .store_wdata(store_wdata));

   task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic base();
      @(negedge clk);
      ex_src1 = 5'd3; ex_src2 = 5'd4; ex_src1_rf = RF1; ex_src2_rf = RF2;
      ex_imm = IMM; ex_npc = NPC; opa_use_npc = 0; opb_use_imm = 0;
      em_wr_en = 0; em_is_load = 0; em_dst = 5'd0; em_result = EMV;
      mw_wr_en = 0; mw_dst = 5'd0; mw_result = MWV;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_idle();
      base(); settle();
      chk("R1", "alu_a idle", alu_a, RF1);
      chk("R1", "alu_b idle", alu_b, RF2);
      chk("R1", "store idle", store_wdata, RF2);
      // R1: destinations written but not matching
      base(); em_wr_en = 1; em_dst = 5'd7; mw_wr_en = 1; mw_dst = 5'd9; settle();
      chk("R1", "alu_a no match", alu_a, RF1);
      chk("R1", "alu_b no match", alu_b, RF2);
   endtask

   task automatic t_em();
      base(); em_wr_en = 1; em_dst = 5'd3; settle();
      chk("R2", "alu_a from em", alu_a, EMV);
      chk("R2", "alu_b untouched", alu_b, RF2);
      base(); em_wr_en = 1; em_dst = 5'd4; settle();
      chk("R2", "alu_b from em", alu_b, EMV);
      chk("R2", "alu_a untouched", alu_a, RF1);
   endtask

   task automatic t_mw();
      base(); mw_wr_en = 1; mw_dst = 5'd4; settle();
      chk("R3", "alu_b from mw", alu_b, MWV);
      chk("R3", "alu_a untouched", alu_a, RF1);
      base(); ex_src2 = 5'd3; mw_wr_en = 1; mw_dst = 5'd3; settle();
      chk("R3", "both sources from mw a", alu_a, MWV);
      chk("R3", "both sources from mw b", alu_b, MWV);
   endtask

   task automatic t_priority();
      base(); em_wr_en = 1; em_dst = 5'd3; mw_wr_en = 1; mw_dst = 5'd3; settle();
      chk("R4", "em wins on a", alu_a, EMV);
      base(); em_wr_en = 1; em_dst = 5'd4; mw_wr_en = 1; mw_dst = 5'd3; settle();
      chk("R4", "split a from mw", alu_a, MWV);
      chk("R4", "split b from em", alu_b, EMV);
   endtask

   task automatic t_wren();
      base(); em_dst = 5'd3; mw_dst = 5'd4; settle();
      chk("R5", "em disabled a", alu_a, RF1);
      chk("R5", "mw disabled b", alu_b, RF2);
      base(); em_dst = 5'd3; mw_wr_en = 1; mw_dst = 5'd3; settle();
      chk("R5", "disabled em falls to mw", alu_a, MWV);
   endtask

   task automatic t_zero();
      base(); ex_src1 = 5'd0; ex_src1_rf = 32'h0; em_wr_en = 1; em_dst = 5'd0;
      mw_wr_en = 1; mw_dst = 5'd0; settle();
      chk("R6", "reg0 not forwarded", alu_a, 32'h0);
      chk("R6", "other source unaffected", alu_b, RF2);
   endtask

   task automatic t_load();
      base(); em_wr_en = 1; em_is_load = 1; em_dst = 5'd3; settle();
      chk("R7", "load em not forwarded", alu_a, RF1);
      base(); em_wr_en = 1; em_is_load = 1; em_dst = 5'd4; mw_wr_en = 1; mw_dst = 5'd4; settle();
      chk("R7", "load em falls to mw", alu_b, MWV);
      chk("R7", "store data falls to mw", store_wdata, MWV);
   endtask

   task automatic t_sel();
      base(); opa_use_npc = 1; opb_use_imm = 1; em_wr_en = 1; em_dst = 5'd3; settle();
      chk("R8", "npc on a overrides bypass", alu_a, NPC);
      chk("R8", "imm on b", alu_b, IMM);
   endtask

   task automatic t_store();
      base(); opb_use_imm = 1; em_wr_en = 1; em_dst = 5'd4; settle();
      chk("R9", "store data forwarded with imm", store_wdata, EMV);
      chk("R9", "alu_b still imm", alu_b, IMM);
      base(); opb_use_imm = 1; mw_wr_en = 1; mw_dst = 5'd4; settle();
      chk("R9", "store data from mw", store_wdata, MWV);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_em();
      t_mw();
      t_priority();
      t_wren();
      t_zero();
      t_load();
      t_sel();
      t_store();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule